// File: doc/BRIEF.md
# Bidirectional Parallel Port Host Handshake Engine

This block is the host end of an enhanced-capabilities parallel link. It moves bytes over an 8-bit bus with interlocked strobe and acknowledge handshakes. In the forward direction it takes bytes from an upstream valid/ready stream and strobes them to the peripheral. Each byte carries a flag that says whether it is data or a command, and the block shows that flag on the host acknowledge line. In the reverse direction it latches the bytes that the peripheral drives. It tags each one as data or command from the peripheral acknowledge level and offers it on a downstream valid/ready stream.

The direction changes only through an interlocked request/acknowledge pair. The host stops driving the bus before it requests a reversal. It takes the bus back only after it has released the request and the peripheral has raised its reversal acknowledge again. A programmable timeout aborts any handshake wait that runs too long and returns the engine to forward idle. All peripheral control inputs pass through a synchronizer first.

Top module: `ecp_host_engine`

## Requirements
- R1: After reset the strobe (host_clk_no), reverse request (rev_req_no) and host acknowledge (host_ack_no) are high, the bus is driven (pd_oe_o=1), rev_valid_o is 0, and fwd_ready_o is 1 while busy_i is low and dir_req_i is 0.
- R2: A forward byte is accepted only when busy_i is low and dir_req_i is 0. While busy_i is high or dir_req_i is 1, fwd_ready_o is 0.
- R3: For each forward byte, pd_o carries the byte and host_ack_no is 1 for a data byte (fwd_cmd_i=0) and 0 for a command byte (fwd_cmd_i=1). This holds by the time host_clk_no goes low.
- R4: host_clk_no goes low only after a setup cycle, stays low until busy_i rises, and then returns high. pd_o does not change while host_clk_no is low.
- R5: When dir_req_i=1, pd_oe_o drops to 0 at least one cycle before rev_req_no falls. pd_oe_o stays 0 while rev_req_no is low.
- R6: In reverse, when periph_clk_ni goes low, the byte on pd_i is offered on rev_data_o with rev_cmd_o=1 if busy_i is low and 0 if it is high. host_ack_no stays low until rev_valid_o/rev_ready_i complete. It then goes high, and returns low after periph_clk_ni goes high.
- R7: While rev_valid_o=1 and rev_ready_i=0, rev_valid_o stays 1 and rev_data_o and rev_cmd_o stay unchanged.
- R8: When dir_req_i returns to 0, rev_req_no goes high while pd_oe_o is still 0. pd_oe_o becomes 1 only after ack_rev_ni is high.
- R9: With timeout_i=N>0, a handshake wait that gets no edge within N cycles produces a one-cycle pulse on timeout_o. The engine then returns to forward idle with host_clk_no and rev_req_no high.
- R10: With timeout_i=0 the timer is off. A wait lasts until the peripheral responds and timeout_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timeout_i | input | TW | Handshake timeout in cycles, 0 disables |
| dir_req_i | input | 1 | 1 requests reverse direction, 0 forward |
| fwd_valid_i | input | 1 | Forward byte valid |
| fwd_ready_o | output | 1 | Forward byte accepted |
| fwd_data_i | input | 8 | Forward byte |
| fwd_cmd_i | input | 1 | Forward byte is a command |
| rev_valid_o | output | 1 | Reverse byte valid |
| rev_ready_i | input | 1 | Reverse byte taken |
| rev_data_o | output | 8 | Reverse byte |
| rev_cmd_o | output | 1 | Reverse byte is a command |
| timeout_o | output | 1 | One-cycle pulse on handshake timeout |
| pd_o | output | 8 | Bus value driven by host |
| pd_oe_o | output | 1 | Bus output enable |
| pd_i | input | 8 | Bus value seen from peripheral |
| host_clk_no | output | 1 | Forward strobe, active low |
| host_ack_no | output | 1 | Host acknowledge / command flag |
| rev_req_no | output | 1 | Reverse request, active low |
| periph_clk_ni | input | 1 | Peripheral strobe, active low |
| busy_i | input | 1 | Peripheral busy / reverse data-command flag |
| ack_rev_ni | input | 1 | Peripheral reversal acknowledge, active low |

## Verification
Forward runs mix data and command bytes, including all-zero and alternating bit patterns, so a swapped flag polarity or a lost bit shows up on pd_o and host_ack_no. Reverse runs present both busy_i levels with different bytes and keep the downstream stalled for several cycles, which tells correct command tagging and holding apart from early acknowledgement. Direction changes both ways check the order of enable, request and acknowledge. Directed cases cover a busy peripheral, a pending direction request, a timeout with a finite limit, and a peripheral that never answers while the timer is off.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  typedef enum logic [3:0] {
    ST_FIDLE, ST_FSETUP, ST_FSTROBE, ST_TOREV, ST_REVREQ,
    ST_RIDLE, ST_RVALID, ST_RACK, ST_TOFWD
  } ecp_state_e;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ecp_timer.sv
module ecp_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (limit_i != '0) && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/ecp_host_engine.sv
module ecp_host_engine
  import ecp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] timeout_i,
  input  logic          dir_req_i,
  input  logic          fwd_valid_i,
  output logic          fwd_ready_o,
  input  logic [DW-1:0] fwd_data_i,
  input  logic          fwd_cmd_i,
  output logic          rev_valid_o,
  input  logic          rev_ready_i,
  output logic [DW-1:0] rev_data_o,
  output logic          rev_cmd_o,
  output logic          timeout_o,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe_o,
  input  logic [DW-1:0] pd_i,
  output logic          host_clk_no,
  output logic          host_ack_no,
  output logic          rev_req_no,
  input  logic          periph_clk_ni,
  input  logic          busy_i,
  input  logic          ack_rev_ni
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] sync_s;
  logic busy_s, pclk_ns, ackrev_ns;

  ecp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ack_rev_ni, periph_clk_ni, busy_i}),
    .q_o    (sync_s)
  );
  assign {ackrev_ns, pclk_ns, busy_s} = sync_s;

  ecp_state_e state_q, state_d;
  logic expired, waiting, tmo, accept, rcap;
  logic [DW-1:0] fdata_q, rdata_q;
  logic fack_q, rcmd_q, tmo_q;

  ecp_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (state_d != state_q),
    .limit_i   (timeout_i),
    .expired_o (expired)
  );

  assign waiting = (state_q == ST_FSTROBE) || (state_q == ST_REVREQ) ||
                   (state_q == ST_RACK)    || (state_q == ST_TOFWD);
  assign tmo     = waiting && expired;
  assign fwd_ready_o = (state_q == ST_FIDLE) && !busy_s && !dir_req_i;
  assign accept  = fwd_ready_o && fwd_valid_i;
  assign rcap    = (state_q == ST_RIDLE) && !pclk_ns;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FIDLE:   if (dir_req_i) state_d = ST_TOREV;
                  else if (accept) state_d = ST_FSETUP;
      ST_FSETUP:  state_d = ST_FSTROBE;
      ST_FSTROBE: if (busy_s) state_d = ST_FIDLE;
      ST_TOREV:   state_d = ST_REVREQ;
      ST_REVREQ:  if (!ackrev_ns) state_d = ST_RIDLE;
      ST_RIDLE:   if (!pclk_ns) state_d = ST_RVALID;
                  else if (!dir_req_i) state_d = ST_TOFWD;
      ST_RVALID:  if (rev_ready_i) state_d = ST_RACK;
      ST_RACK:    if (pclk_ns) state_d = ST_RIDLE;
      ST_TOFWD:   if (ackrev_ns) state_d = ST_FIDLE;
      default:    state_d = ST_FIDLE;
    endcase
    if (tmo) state_d = ST_FIDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FIDLE;
      fdata_q <= '0;
      fack_q  <= 1'b1;
      rdata_q <= '0;
      rcmd_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo;
      if (accept) begin
        fdata_q <= fwd_data_i;
        fack_q  <= !fwd_cmd_i;
      end
      if (rcap) begin
        rdata_q <= pd_i;
        rcmd_q  <= !busy_s;
      end
    end
  end

  logic fwd_st;
  assign fwd_st      = (state_q == ST_FIDLE) || (state_q == ST_FSETUP) ||
                       (state_q == ST_FSTROBE);
  assign pd_o        = fdata_q;
  assign pd_oe_o     = fwd_st && ackrev_ns;
  assign host_clk_no = (state_q != ST_FSTROBE);
  assign host_ack_no = fwd_st ? fack_q :
                       ((state_q == ST_RACK) || (state_q == ST_TOFWD) ||
                        (state_q == ST_TOREV));
  assign rev_req_no  = !((state_q == ST_REVREQ) || (state_q == ST_RIDLE) ||
                         (state_q == ST_RVALID) || (state_q == ST_RACK));
  assign rev_valid_o = (state_q == ST_RVALID);
  assign rev_data_o  = rdata_q;
  assign rev_cmd_o   = rcmd_q;
  assign timeout_o   = tmo_q;

  // R5: bus released while reverse requested
  p_no_drive_in_rev_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_oe_o |-> rev_req_no);
  // R5: enable dropped before request asserted
  p_release_before_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rev_req_no) |-> $past(!pd_oe_o));
  // R4: bus stable under strobe
  p_bus_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_clk_no && $past(!host_clk_no)) |-> $stable(pd_o));
  // R2: strobe only follows an accept with busy low
  p_strobe_after_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_clk_no) |-> $past(fwd_ready_o && fwd_valid_i, 2));
  // R7: reverse byte held until taken
  p_rev_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rev_valid_o && !rev_ready_i) |=> (rev_valid_o && $stable(rev_data_o) && $stable(rev_cmd_o)));
  // R9: single-cycle timeout pulse
  p_tmo_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  // R9: after timeout the engine is idle
  p_tmo_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (host_clk_no && rev_req_no));
endmodule

// File: tb/tb_ecp_host_engine.sv
`timescale 1ns/1ps
module tb_ecp_host_engine;
  localparam int TW = 16;

  logic clk = 0, rst_ni = 0;
  logic [TW-1:0] timeout_i = 16'd40;
  logic dir_req_i = 0, fwd_valid_i = 0, fwd_cmd_i = 0, rev_ready_i = 0;
  logic [7:0] fwd_data_i = 0, pd_i = 0;
  logic periph_clk_ni = 1, busy_i = 0, ack_rev_ni = 1;
  logic fwd_ready_o, rev_valid_o, rev_cmd_o, timeout_o, pd_oe_o;
  logic host_clk_no, host_ack_no, rev_req_no;
  logic [7:0] rev_data_o, pd_o;

  always #2.5 clk = ~clk;

  ecp_host_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .timeout_i(timeout_i), .dir_req_i(dir_req_i),
    .fwd_valid_i(fwd_valid_i), .fwd_ready_o(fwd_ready_o), .fwd_data_i(fwd_data_i),
    .fwd_cmd_i(fwd_cmd_i), .rev_valid_o(rev_valid_o), .rev_ready_i(rev_ready_i),
    .rev_data_o(rev_data_o), .rev_cmd_o(rev_cmd_o), .timeout_o(timeout_o),
    .pd_o(pd_o), .pd_oe_o(pd_oe_o), .pd_i(pd_i), .host_clk_no(host_clk_no),
    .host_ack_no(host_ack_no), .rev_req_no(rev_req_no), .periph_clk_ni(periph_clk_ni),
    .busy_i(busy_i), .ack_rev_ni(ack_rev_ni)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {dir(1=reverse), cmd, data}
  localparam logic [9:0] VEC [7] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b1, 8'h3C}, {1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h5A}, {1'b1, 1'b1, 8'h81}, {1'b1, 1'b0, 8'hFF},
    {1'b0, 1'b1, 8'h96}
  };

  task automatic send_fwd(input logic cmd, input logic [7:0] d);
    fwd_data_i = d; fwd_cmd_i = cmd; fwd_valid_i = 1;
    while (!fwd_ready_o) cyc(1);
    cyc(1);
    fwd_valid_i = 0;
    while (host_clk_no) cyc(1);
    check(pd_o == d, "R3 data", pd_o, d);
    check(host_ack_no == !cmd, "R3 flag", host_ack_no, !cmd);
    check(pd_oe_o == 1, "R3 oe", pd_oe_o, 1);
    cyc(3);
    check(host_clk_no == 0, "R4 strobe held", host_clk_no, 0);
    busy_i = 1;
    while (!host_clk_no) cyc(1);
    check(pd_o == d, "R4 stable", pd_o, d);
    cyc(1);
    busy_i = 0;
    cyc(3);
  endtask

  task automatic to_rev();
    dir_req_i = 1;
    while (rev_req_no) begin
      cyc(1);
      if (rev_req_no && !pd_oe_o) check(1, "R5", 0, 0);
    end
    check(pd_oe_o == 0, "R5 oe at req", pd_oe_o, 0);
    ack_rev_ni = 0;
    cyc(4);
    check(pd_oe_o == 0, "R5 oe held", pd_oe_o, 0);
  endtask

  task automatic to_fwd();
    dir_req_i = 0;
    busy_i = 0;
    while (!rev_req_no) cyc(1);
    check(pd_oe_o == 0, "R8 oe at release", pd_oe_o, 0);
    cyc(5);
    check(pd_oe_o == 0, "R8 oe waits ack", pd_oe_o, 0);
    ack_rev_ni = 1;
    cyc(5);
    check(pd_oe_o == 1, "R8 oe back", pd_oe_o, 1);
  endtask

  task automatic recv_rev(input logic cmd, input logic [7:0] d);
    pd_i = d; busy_i = !cmd; periph_clk_ni = 0;
    while (!rev_valid_o) cyc(1);
    check(rev_data_o == d, "R6 data", rev_data_o, d);
    check(rev_cmd_o == cmd, "R6 cmd", rev_cmd_o, cmd);
    check(host_ack_no == 0, "R6 ack low", host_ack_no, 0);
    pd_i = ~d;
    cyc(3);
    check(rev_valid_o && rev_data_o == d, "R7 hold", rev_data_o, d);
    check(host_ack_no == 0, "R6 ack waits ready", host_ack_no, 0);
    rev_ready_i = 1;
    cyc(1);
    rev_ready_i = 0;
    while (!host_ack_no) cyc(1);
    check(rev_valid_o == 0, "R6 valid dropped", rev_valid_o, 0);
    periph_clk_ni = 1;
    while (host_ack_no) cyc(1);
    check(1, "R6 ack returns low", 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic dir_now;
    int el;
    cyc(3);
    rst_ni = 1;
    cyc(4);
    check(host_clk_no == 1, "R1 strobe", host_clk_no, 1);
    check(rev_req_no == 1, "R1 req", rev_req_no, 1);
    check(host_ack_no == 1, "R1 ack", host_ack_no, 1);
    check(pd_oe_o == 1, "R1 oe", pd_oe_o, 1);
    check(rev_valid_o == 0, "R1 valid", rev_valid_o, 0);
    check(fwd_ready_o == 1, "R1 ready", fwd_ready_o, 1);

    // R2: busy and pending direction request block acceptance
    busy_i = 1; fwd_valid_i = 1; fwd_data_i = 8'h11;
    cyc(5);
    check(fwd_ready_o == 0, "R2 busy", fwd_ready_o, 0);
    check(host_clk_no == 1, "R2 no strobe", host_clk_no, 1);
    fwd_valid_i = 0; busy_i = 0;
    cyc(4);
    check(fwd_ready_o == 1, "R2 ready again", fwd_ready_o, 1);

    dir_now = 0;
    for (int i = 0; i < 7; i++) begin
      if (VEC[i][9] != dir_now) begin
        if (VEC[i][9]) to_rev(); else to_fwd();
        dir_now = VEC[i][9];
      end
      if (VEC[i][9]) recv_rev(VEC[i][8], VEC[i][7:0]);
      else           send_fwd(VEC[i][8], VEC[i][7:0]);
    end

    // R2: direction request takes priority
    dir_req_i = 1; fwd_valid_i = 1;
    cyc(1);
    check(fwd_ready_o == 0, "R2 dir_req", fwd_ready_o, 0);
    fwd_valid_i = 0;
    while (rev_req_no) cyc(1);
    ack_rev_ni = 0;
    cyc(4);
    to_fwd();

    // R10: timer disabled, peripheral slow
    timeout_i = 0;
    fwd_data_i = 8'h42; fwd_cmd_i = 0; fwd_valid_i = 1;
    while (!fwd_ready_o) cyc(1);
    cyc(1);
    fwd_valid_i = 0;
    el = 0;
    for (int k = 0; k < 150; k++) begin
      cyc(1);
      if (timeout_o) el++;
    end
    check(el == 0, "R10 no timeout", el, 0);
    check(host_clk_no == 0, "R10 still waiting", host_clk_no, 0);
    busy_i = 1;
    while (!host_clk_no) cyc(1);
    busy_i = 0;
    cyc(4);

    // R9: timeout with limit 20
    timeout_i = 20;
    fwd_data_i = 8'h77; fwd_valid_i = 1;
    while (!fwd_ready_o) cyc(1);
    cyc(1);
    fwd_valid_i = 0;
    while (host_clk_no) cyc(1);
    el = 0;
    while (!timeout_o && el < 200) begin
      cyc(1);
      el++;
    end
    check(el >= 20 && el <= 22, "R9 timeout delay", el, 20);
    check(host_clk_no == 1, "R9 strobe released", host_clk_no, 1);
    cyc(1);
    check(timeout_o == 0, "R9 pulse", timeout_o, 0);
    check(fwd_ready_o == 1, "R9 idle", fwd_ready_o, 1);

    // R9: reverse request timeout
    dir_req_i = 1;
    el = 0;
    while (!timeout_o && el < 200) begin
      cyc(1);
      el++;
    end
    check(timeout_o == 1, "R9 rev timeout", timeout_o, 1);
    check(rev_req_no == 1, "R9 req released", rev_req_no, 1);
    dir_req_i = 0;
    cyc(3);
    check(pd_oe_o == 1, "R9 oe after timeout", pd_oe_o, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule